// File: doc/BRIEF.md
# Load-Use Interlock and Decode-Stage Branch Redirect

This block holds the hazard control for a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. It watches the instruction sitting in decode and the instruction it sent into execute in the previous cycle. When a memory read in execute targets a register that the decode instruction names as a source, the data cannot reach the bypass network in time. The block then freezes the program counter and the fetch/decode register for one cycle and asks the decode control mux to send zeros, so execute receives a bubble.

Conditional branches on equality are resolved in decode. The surrounding datapath supplies the two read operands, already bypassed. Fetch always continues down the fall-through path. When a branch is found to be taken, the block selects the branch target for the next fetch and squashes the fall-through instruction that was already fetched, so a taken branch costs one slot. The block keeps its own one-entry record of the instruction in execute (whether it reads memory, and its destination) and a one-bit record of a squashed decode slot. It has no data stream, so every pin is a plain level-sensitive control or field.

The register file, the bypass muxes, the branch target adder and the pipeline registers themselves sit outside this block.

Top module: `hz_stall_flush_unit`

## Requirements
- R1: A stall (pc_write=0) is raised when the instruction recorded in execute was a memory read (id_is_load high when it left decode) and its destination (its id_rt at that time) equals the current id_rs or id_rt.
- R2: In a stall cycle pc_write=0, ifid_write=0 and ctrl_zero=1; outside a stall or a squashed slot, pc_write=1, ifid_write=1 and ctrl_zero=0.
- R3: Only the instruction immediately after a memory read is compared. A reader two or more slots behind the load never stalls because of it.
- R4: A load-use stall lasts exactly one cycle. The held decode instruction is evaluated again against the bubble and proceeds in the next cycle.
- R5: A branch in decode (id_is_branch=1) is taken when id_op_a equals id_op_b. When they differ, if_flush=0 and pc_src=0.
- R6: A taken branch raises if_flush=1 and pc_src=1 in the same cycle, with pc_write=1.
- R7: In the cycle after if_flush, the decode slot is treated as a no-op. It raises no stall and no branch, ctrl_zero=1, and if it was a memory read it is not recorded as one.
- R8: A stall takes precedence over a branch in the same cycle: if_flush=0 and pc_src=0 while stalled. The branch is decided again in the following cycle.
- R9: A memory read whose destination is register 0 never causes a stall.
- R10: After reset the execute record is empty and no slot is squashed: pc_write=1, ifid_write=1, ctrl_zero=0, if_flush=0, pc_src=0 for any non-branch decode input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | REG_AW | First source register of the decode instruction |
| id_rt | input | REG_AW | Second source register; the destination of a memory read |
| id_is_load | input | 1 | Decode instruction reads data memory |
| id_is_branch | input | 1 | Decode instruction is a branch on equality |
| id_op_a | input | DATA_W | First bypassed read operand in decode |
| id_op_b | input | DATA_W | Second bypassed read operand in decode |
| pc_write | output | 1 | Program counter may update |
| ifid_write | output | 1 | Fetch/decode register may load |
| ctrl_zero | output | 1 | Decode control mux sends zeros into execute |
| if_flush | output | 1 | Turn the fetched fall-through instruction into a no-op |
| pc_src | output | 1 | Next fetch address is the branch target |

## Verification
The stall path is driven with a load followed by a reader that matches on the first source, then on the second source, and with readers one slot further away. This separates the adjacent-only rule from a deeper comparison. A load to register 0 and a plain arithmetic writer followed by a reader confirm that neither the zero register nor a non-memory producer interlocks. Branches are sent with equal and with unequal operands. A taken branch is followed by a load whose reader comes next, which shows whether the squashed slot is really dropped from the execute record. A branch right behind a dependent load shows the ordering of stall before redirect, and back-to-back dependent loads show that each stall stays one cycle long.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    ACT_RUN      = 2'd0,
    ACT_STALL    = 2'd1,
    ACT_REDIRECT = 2'd2,
    ACT_SQUASHED = 2'd3
  } hz_act_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hz_ex_track.sv
module hz_ex_track #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_bubble,
  input  logic              slot_dead,
  input  logic              redirect,
  input  logic              id_is_load,
  input  logic [REG_AW-1:0] id_rt,
  output logic              ex_load,
  output logic [REG_AW-1:0] ex_dst,
  output logic              squash_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_load  <= 1'b0;
      ex_dst   <= '0;
      squash_q <= 1'b0;
    end else begin
      squash_q <= redirect;
      if (hold_bubble || slot_dead) begin
        ex_load <= 1'b0;
        ex_dst  <= '0;
      end else begin
        ex_load <= id_is_load;
        ex_dst  <= id_rt;
      end
    end
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned REG_AW = 5
) (
  input  logic                                 ex_load,
  input  logic [REG_AW-1:0]                    ex_dst,
  input  logic [hz_pkg::NUM_SRC-1:0][REG_AW-1:0] srcs,
  input  logic                                 slot_dead,
  output logic                                 need_stall
);
  import hz_pkg::*;
  logic [NUM_SRC-1:0] hit;
  logic               dst_live;

  assign dst_live = ex_load && (ex_dst != '0);

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign hit[s] = dst_live && (srcs[s] == ex_dst);
    end
  endgenerate

  assign need_stall = (|hit) && !slot_dead;
endmodule

// File: rtl/hz_branch_eval.sv
module hz_branch_eval #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              is_branch,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              blocked,
  output logic              taken
);
  logic [DATA_W-1:0] diff;
  assign diff  = op_a ^ op_b;
  assign taken = is_branch && !blocked && (diff == '0);
endmodule

// File: rtl/hz_stall_flush_unit.sv
module hz_stall_flush_unit #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_is_load,
  input  logic              id_is_branch,
  input  logic [DATA_W-1:0] id_op_a,
  input  logic [DATA_W-1:0] id_op_b,
  output logic              pc_write,
  output logic              ifid_write,
  output logic              ctrl_zero,
  output logic              if_flush,
  output logic              pc_src
);
  import hz_pkg::*;

  logic              ex_load;
  logic [REG_AW-1:0] ex_dst;
  logic              squash_q;
  logic              stall;
  logic              taken;
  logic              blocked;
  hz_act_e           act;
  logic [NUM_SRC-1:0][REG_AW-1:0] srcs;

  assign srcs[0] = id_rs;
  assign srcs[1] = id_rt;
  assign blocked = stall || squash_q;

  hz_ex_track #(.REG_AW(REG_AW)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_bubble (stall),
    .slot_dead   (squash_q),
    .redirect    (taken),
    .id_is_load  (id_is_load),
    .id_rt       (id_rt),
    .ex_load     (ex_load),
    .ex_dst      (ex_dst),
    .squash_q    (squash_q)
  );

  hz_load_use #(.REG_AW(REG_AW)) u_lu (
    .ex_load    (ex_load),
    .ex_dst     (ex_dst),
    .srcs       (srcs),
    .slot_dead  (squash_q),
    .need_stall (stall)
  );

  hz_branch_eval #(.DATA_W(DATA_W)) u_br (
    .is_branch (id_is_branch),
    .op_a      (id_op_a),
    .op_b      (id_op_b),
    .blocked   (blocked),
    .taken     (taken)
  );

  always_comb begin
    if (squash_q)   act = ACT_SQUASHED;
    else if (stall) act = ACT_STALL;
    else if (taken) act = ACT_REDIRECT;
    else            act = ACT_RUN;
  end

  always_comb begin
    pc_write   = 1'b1;
    ifid_write = 1'b1;
    ctrl_zero  = 1'b0;
    if_flush   = 1'b0;
    pc_src     = 1'b0;
    unique case (act)
      ACT_STALL: begin
        pc_write   = 1'b0;
        ifid_write = 1'b0;
        ctrl_zero  = 1'b1;
      end
      ACT_REDIRECT: begin
        if_flush = 1'b1;
        pc_src   = 1'b1;
      end
      ACT_SQUASHED: ctrl_zero = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/hz_stall_flush_chk.sv
module hz_stall_flush_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic [REG_AW-1:0] ex_dst,
  input logic              ex_load,
  input logic              pc_write,
  input logic              ifid_write,
  input logic              ctrl_zero,
  input logic              if_flush,
  input logic              pc_src
);
  // R2
  a_r2_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_write && !ifid_write && ctrl_zero));
  // R4
  a_r4_one_cycle_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  // R6
  a_r6_flush_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> (pc_src && pc_write));
  // R7
  a_r7_slot_after_flush_dead: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |=> (!if_flush && !stall && ctrl_zero));
  // R8
  a_r8_stall_before_branch: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_write |-> (!if_flush && !pc_src));
  // R9
  a_r9_zero_dst_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && ex_dst == '0) |-> !stall);
endmodule

bind hz_stall_flush_unit hz_stall_flush_chk #(.REG_AW(REG_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .ex_dst     (ex_dst),
  .ex_load    (ex_load),
  .pc_write   (pc_write),
  .ifid_write (ifid_write),
  .ctrl_zero  (ctrl_zero),
  .if_flush   (if_flush),
  .pc_src     (pc_src)
);

// File: tb/hz_stall_flush_unit_tb_top.sv
module hz_stall_flush_unit_tb_top;
  localparam int RAW = 5;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RAW-1:0] id_rs = '0, id_rt = '0;
  logic id_is_load = 1'b0, id_is_branch = 1'b0;
  logic [DW-1:0] id_op_a = '0, id_op_b = '0;
  logic pc_write, ifid_write, ctrl_zero, if_flush, pc_src;

  int checks = 0;
  int fails  = 0;

  // reference state
  bit m_ex_load = 0;
  int m_ex_dst  = 0;
  bit m_squash  = 0;

  always #4 clk = ~clk;

  hz_stall_flush_unit #(.REG_AW(RAW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
    .id_is_load(id_is_load), .id_is_branch(id_is_branch),
    .id_op_a(id_op_a), .id_op_b(id_op_b),
    .pc_write(pc_write), .ifid_write(ifid_write), .ctrl_zero(ctrl_zero),
    .if_flush(if_flush), .pc_src(pc_src)
  );

  task automatic check_bits(string tag, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s outputs {pcw,ifw,cz,fl,src} actual=%b expected=%b at %0t",
               tag, got, exp, $time);
    end
  endtask

  task automatic check_int(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s cycle count actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // Issue one decode instruction; repeats while the reference says stall.
  task automatic issue(string tag, bit ld, bit br, int rs, int rt,
                       int a, int b, output int cyc);
    bit e_stall, e_taken;
    cyc = 0;
    forever begin
      @(negedge clk);
      id_rs = RAW'(rs); id_rt = RAW'(rt);
      id_is_load = ld; id_is_branch = br;
      id_op_a = DW'(a); id_op_b = DW'(b);
      #1;
      e_stall = !m_squash && m_ex_load && (m_ex_dst != 0) &&
                ((m_ex_dst == rs) || (m_ex_dst == rt));
      e_taken = !m_squash && !e_stall && br && (a == b);
      check_bits(tag, {pc_write, ifid_write, ctrl_zero, if_flush, pc_src},
                 {!e_stall, !e_stall, e_stall || m_squash, e_taken, e_taken});
      @(posedge clk);
      cyc++;
      if (e_stall || m_squash) begin m_ex_load = 0; m_ex_dst = 0; end
      else begin m_ex_load = ld; m_ex_dst = rt; end
      m_squash = e_taken;
      if (!e_stall) break;
    end
  endtask

  task automatic nop_gap();
    int c;
    issue("R10", 0, 0, 0, 0, 0, 0, c);
    issue("R10", 0, 0, 0, 0, 0, 0, c);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    int c, tot;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check_bits("R10 reset", {pc_write, ifid_write, ctrl_zero, if_flush, pc_src}, 5'b11000);

    // R1/R2/R4: load r5, reader on rs
    issue("R1", 1, 0, 1, 5, 0, 0, c); tot = c;
    issue("R1 R2 rs match", 0, 0, 5, 2, 0, 0, c); tot += c;
    check_int("R4 load+use rs", tot, 3);
    nop_gap();
    // R1: reader on rt
    issue("R1", 1, 0, 1, 6, 0, 0, c); tot = c;
    issue("R1 rt match", 0, 0, 3, 6, 0, 0, c); tot += c;
    check_int("R4 load+use rt", tot, 3);
    nop_gap();
    // R3: reader two slots behind
    issue("R3", 1, 0, 1, 7, 0, 0, c); tot = c;
    issue("R3", 0, 0, 2, 3, 0, 0, c); tot += c;
    issue("R3 distant reader", 0, 0, 7, 7, 0, 0, c); tot += c;
    check_int("R3 no stall", tot, 3);
    nop_gap();
    // R9: load to r0
    issue("R9", 1, 0, 1, 0, 0, 0, c); tot = c;
    issue("R9 zero dst", 0, 0, 0, 0, 0, 0, c); tot += c;
    check_int("R9 no stall", tot, 2);
    // non-load writer then reader
    issue("R1 nonload", 0, 0, 1, 8, 0, 0, c); tot = c;
    issue("R1 nonload reader", 0, 0, 8, 8, 0, 0, c); tot += c;
    check_int("R1 nonload no stall", tot, 2);
    nop_gap();
    // R5/R6/R7: taken branch, squashed load, then its would-be reader
    issue("R6 taken", 0, 1, 1, 2, 42, 42, c); tot = c;
    issue("R7 squashed slot", 1, 1, 1, 9, 3, 3, c); tot += c;
    issue("R7 reader of squashed load", 0, 0, 9, 9, 0, 0, c); tot += c;
    check_int("R7 flush cost", tot, 3);
    nop_gap();
    // R5: not taken
    issue("R5 not taken", 0, 1, 1, 2, 42, 43, c);
    check_int("R5 not taken cycles", c, 1);
    nop_gap();
    // R8: load r3 then branch on r3
    issue("R8", 1, 0, 1, 3, 0, 0, c); tot = c;
    issue("R8 stall then branch", 0, 1, 3, 4, 11, 11, c); tot += c;
    issue("R8 squashed", 0, 0, 0, 0, 0, 0, c); tot += c;
    check_int("R8 cycles", tot, 4);
    nop_gap();
    // R4: chained loads
    issue("R4", 1, 0, 1, 4, 0, 0, c); tot = c;
    issue("R4 load uses load", 1, 0, 4, 6, 0, 0, c); tot += c;
    issue("R4 second use", 0, 0, 6, 1, 0, 0, c); tot += c;
    check_int("R4 chained", tot, 5);
    nop_gap();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule